// File: doc/BRIEF.md
# Dual-Section Dot-Matrix LCD Segment/Common Shifter

This block is the digital core of a 40-channel dot-matrix LCD driver. It holds two independent sections of `CH` channels each (20 by default). Every section has three parts: a bidirectional serial shift register, a parallel hold latch, and one output level selector per channel. A controller feeds serial dot data on one end pin of each section and pulses two strobes. One strobe moves the data along the register. The other copies the whole register into the latch, and the latch sets the bias level of every channel. The pin at the far end of each register carries the bit that is shifted out, so several devices can be chained.

The strobes and the serial data pins come from a slow controller and are sampled in the system clock domain. All actions happen on the falling edge of a strobe. A mode input lets one device drive segments and commons at the same time. In that mode, section 2 swaps the roles of the two strobes and uses the inverted alternation signal. Each channel output is a 2-bit level code, which the analog switches outside this block decode.

Top module: `lcd_dual_driver`

## Requirements
- R1: While `rst_n` is low at a clock edge, all shift registers and latches clear to 0 and all four serial output enables go low. With the alternation input low, every channel then reads code 2'b10 in section 1. In section 2 it reads 2'b10 in normal mode and 2'b11 in dual mode.
- R2: With a section's direction input low, data enters on its left pin. Each shift moves the bits toward higher channel numbers, so the first of `CH` shifted bits lands on the section's last channel. The right pin drives the bit held at the last channel.
- R3: With a section's direction input high, data enters on its right pin. Each shift moves the bits toward lower channel numbers, so the first of `CH` shifted bits lands on the section's first channel. The left pin drives the bit held at the first channel.
- R4: Out of reset, the output enable is high on exactly the one pin of each section that is not the input, and the other pin's output reads 0. The input pin on the output side is ignored.
- R5: A bit shifted in comes out of the far-end pin after exactly `CH` shifts, so devices can be cascaded.
- R6: With `dual_mode` low, both sections shift on a falling edge of `shift_stb` and latch on a falling edge of `latch_stb`.
- R7: With `dual_mode` high, section 1 keeps the roles given in R6. Section 2 shifts on a falling edge of `latch_stb` and latches on a falling edge of `shift_stb`.
- R8: Channel i (0-based, section 2 holding channels CH..2CH-1) drives `lvl_out[2i+1:2i]` = {~latched bit, effective alternation}. The codes mean 00 = select A, 01 = select B, 10 = nonselect A and 11 = nonselect B. The effective alternation is `alt_in`, except in section 2 with `dual_mode` high, where it is inverted.
- R9: Channel outputs change only through a latch action or a change of the alternation input. Shifting alone leaves them unchanged.
- R10: Rising strobe edges neither shift nor latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_stb | input | 1 | Strobe that normally shifts (falling edge) |
| latch_stb | input | 1 | Strobe that normally latches (falling edge) |
| alt_in | input | 1 | Alternation signal for output polarity |
| dual_mode | input | 1 | High: section 2 acts as common driver |
| dir_sec1 | input | 1 | Section 1 direction (high: right pin is input) |
| dir_sec2 | input | 1 | Section 2 direction (high: right pin is input) |
| s1_l_in | input | 1 | Section 1 left pin, input side |
| s1_l_out | output | 1 | Section 1 left pin, output value |
| s1_l_oe | output | 1 | Section 1 left pin, output enable |
| s1_r_in | input | 1 | Section 1 right pin, input side |
| s1_r_out | output | 1 | Section 1 right pin, output value |
| s1_r_oe | output | 1 | Section 1 right pin, output enable |
| s2_l_in | input | 1 | Section 2 left pin, input side |
| s2_l_out | output | 1 | Section 2 left pin, output value |
| s2_l_oe | output | 1 | Section 2 left pin, output enable |
| s2_r_in | input | 1 | Section 2 right pin, input side |
| s2_r_out | output | 1 | Section 2 right pin, output value |
| s2_r_oe | output | 1 | Section 2 right pin, output enable |
| lvl_out | output | 4*CH | Two-bit level code per channel, channel i at bits 2i+1:2i |

## Verification
The bench sweeps both modes, all four direction pairs and both alternation levels. It shifts a full register's worth of data through each section, and every strobe is followed by a comparison against a bench-side shift and latch model. The corner cases are these:
- **Dual-mode strobe swap.** A design that ignored it would fill section 2 from the wrong strobe, and its latched pattern would be a shifted copy rather than the data sent.
- **Reversed bit order in one direction.** The picture would appear mirrored.
- **Wrong cascade pin.** Chained devices would receive 0 or stale data.
- **Acting on rising edges.** Outputs would move half a strobe early.
- **Driving the input-side pin.** This would fight the controller.

The bench also drives a conflicting value on the output-side input pin to show that it is ignored.

// File: rtl/lcdd_pkg.sv
// Shared types for the dual-section LCD shifter: the per-channel level code
// and the mapping from a latched dot and alternation phase to that code.
package lcdd_pkg;

    typedef enum logic [1:0] {
        LV_SEL_A  = 2'b00,
        LV_SEL_B  = 2'b01,
        LV_NSEL_A = 2'b10,
        LV_NSEL_B = 2'b11
    } lvl_e;

    // Map a latched dot (1 = selected) and effective alternation to a level.
    function automatic lvl_e lvl_of(input logic dot, input logic alt);
        return lvl_e'({~dot, alt});
    endfunction

endpackage

// File: rtl/lcdd_sync.sv
// Multi-bit synchronizer: STAGES flops per bit, synchronous active-low reset
// to 0. Assumes each input bit is a slow level, so bits may skew by one cycle
// against each other only when they change within one clock.
module lcdd_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Stage s of the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n)      chain[s] <= '0;
                else if (s == 0) chain[s] <= d;
                else             chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lcdd_fall.sv
// Falling-edge detector on an already synchronized level. Emits a one-cycle
// pulse the cycle after the level is seen going from 1 to 0.
module lcdd_fall (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);
    logic prev_q;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign fall = prev_q & ~lvl;
endmodule

// File: rtl/lcdd_section.sv
// One driver section: a CH-bit bidirectional shift register, a CH-bit latch
// and CH level selectors. Assumes shift_p / latch_p are single-cycle pulses
// and that data inputs are already aligned with those pulses.
module lcdd_section
    import lcdd_pkg::*;
#(
    parameter int CH = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_p,
    input  logic            latch_p,
    input  logic            dir,
    input  logic            alt_eff,
    input  logic            l_in,
    input  logic            r_in,
    output logic            l_out,
    output logic            l_oe,
    output logic            r_out,
    output logic            r_oe,
    output logic [CH-1:0]   lat_q,
    output logic [2*CH-1:0] lvl
);
    logic [CH-1:0] sr_q;

    // Shift: dir low fills from left toward high index; dir high mirrors it.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr_q <= '0;
        else if (shift_p) sr_q <= dir ? {r_in, sr_q[CH-1:1]} : {sr_q[CH-2:0], l_in};
    end

    // Parallel copy of the whole register into the hold latch.
    always_ff @(posedge clk) begin
        if (!rst_n)       lat_q <= '0;
        else if (latch_p) lat_q <= sr_q;
    end

    // Output enables follow direction; reset releases both pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_oe <= 1'b0;
            r_oe <= 1'b0;
        end else begin
            l_oe <= dir;
            r_oe <= ~dir;
        end
    end

    assign l_out = l_oe & sr_q[0];
    assign r_out = r_oe & sr_q[CH-1];

    generate
        for (genvar i = 0; i < CH; i++) begin : g_chan
            assign lvl[2*i +: 2] = lvl_of(lat_q[i], alt_eff);
        end
    endgenerate
endmodule

// File: rtl/lcd_dual_driver.sv
// Top of the dual-section LCD shifter. Synchronizes strobes, alternation and
// serial inputs, detects strobe falling edges and routes shift/latch roles to
// the two sections according to dual_mode. Assumes dual_mode and the
// direction inputs are static while strobes toggle.
module lcd_dual_driver
    import lcdd_pkg::*;
#(
    parameter int CH     = 20,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_stb,
    input  logic            latch_stb,
    input  logic            alt_in,
    input  logic            dual_mode,
    input  logic            dir_sec1,
    input  logic            dir_sec2,
    input  logic            s1_l_in,
    output logic            s1_l_out,
    output logic            s1_l_oe,
    input  logic            s1_r_in,
    output logic            s1_r_out,
    output logic            s1_r_oe,
    input  logic            s2_l_in,
    output logic            s2_l_out,
    output logic            s2_l_oe,
    input  logic            s2_r_in,
    output logic            s2_r_out,
    output logic            s2_r_oe,
    output logic [4*CH-1:0] lvl_out
);
    localparam int SW = 7;

    logic [SW-1:0] raw_w, syn_w;
    logic [1:0]    fall_w;
    logic          sh1, lt1, sh2, lt2, alt_s;
    logic [CH-1:0] lat1_w, lat2_w;

    assign raw_w = {s2_r_in, s2_l_in, s1_r_in, s1_l_in, alt_in, latch_stb, shift_stb};
    assign alt_s = syn_w[2];

    lcdd_sync #(.W(SW), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_w), .q(syn_w)
    );

    generate
        for (genvar k = 0; k < 2; k++) begin : g_edge
            lcdd_fall u_fall (.clk(clk), .rst_n(rst_n), .lvl(syn_w[k]), .fall(fall_w[k]));
        end
    endgenerate

    // Role routing: section 2 swaps strobes in dual mode.
    always_comb begin
        sh1 = fall_w[0];
        lt1 = fall_w[1];
        sh2 = dual_mode ? fall_w[1] : fall_w[0];
        lt2 = dual_mode ? fall_w[0] : fall_w[1];
    end

    lcdd_section #(.CH(CH)) u_sec1 (
        .clk(clk), .rst_n(rst_n), .shift_p(sh1), .latch_p(lt1), .dir(dir_sec1),
        .alt_eff(alt_s), .l_in(syn_w[3]), .r_in(syn_w[4]),
        .l_out(s1_l_out), .l_oe(s1_l_oe), .r_out(s1_r_out), .r_oe(s1_r_oe),
        .lat_q(lat1_w), .lvl(lvl_out[2*CH-1:0])
    );

    lcdd_section #(.CH(CH)) u_sec2 (
        .clk(clk), .rst_n(rst_n), .shift_p(sh2), .latch_p(lt2), .dir(dir_sec2),
        .alt_eff(alt_s ^ dual_mode), .l_in(syn_w[5]), .r_in(syn_w[6]),
        .l_out(s2_l_out), .l_oe(s2_l_oe), .r_out(s2_r_out), .r_oe(s2_r_oe),
        .lat_q(lat2_w), .lvl(lvl_out[4*CH-1:2*CH])
    );
endmodule

// File: rtl/lcdd_checker.sv
// Assertion checker for lcd_dual_driver, attached by bind below.
module lcdd_checker #(
    parameter int CH = 20
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dual_mode,
    input logic            sh1,
    input logic            lt1,
    input logic            sh2,
    input logic            lt2,
    input logic [CH-1:0]   lat1,
    input logic [CH-1:0]   lat2,
    input logic [3:0]      oe,
    input logic [4*CH-1:0] lvl_out
);
    logic rst_seen_q;

    // Track that reset was applied at the previous edge.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
        if (rst_seen_q)
            a_r1_reset_clear: assert (oe == 4'b0 && lat1 == '0 && lat2 == '0)
                else $error("R1 reset did not clear state");
    end

    a_r4_oe_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        !(oe[0] && oe[1]) && !(oe[2] && oe[3]));

    a_r6_normal_roles: assert property (@(posedge clk) disable iff (!rst_n)
        !dual_mode |-> (sh1 == sh2) && (lt1 == lt2));

    a_r7_dual_swap: assert property (@(posedge clk) disable iff (!rst_n)
        dual_mode |-> (sh2 == lt1) && (lt2 == sh1));

    a_r9_hold_sec1: assert property (@(posedge clk) disable iff (!rst_n)
        !lt1 |=> $stable(lat1));

    a_r9_hold_sec2: assert property (@(posedge clk) disable iff (!rst_n)
        !lt2 |=> $stable(lat2));

    a_r8_alt_inverted: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_out[0] == lvl_out[2*CH]) == !dual_mode);
endmodule

bind lcd_dual_driver lcdd_checker #(.CH(CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode),
    .sh1(sh1), .lt1(lt1), .sh2(sh2), .lt2(lt2),
    .lat1(lat1_w), .lat2(lat2_w),
    .oe({s2_r_oe, s2_l_oe, s1_r_oe, s1_l_oe}),
    .lvl_out(lvl_out)
);

// File: tb/sim_lcd_dual_driver.sv
module sim_lcd_dual_driver;
    localparam int N = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_stb = 1'b0, latch_stb = 1'b0, alt_in = 1'b0, dual_mode = 1'b0;
    logic dir_sec1 = 1'b0, dir_sec2 = 1'b0;
    logic s1_l_in = 1'b0, s1_r_in = 1'b0, s2_l_in = 1'b0, s2_r_in = 1'b0;
    logic s1_l_out, s1_l_oe, s1_r_out, s1_r_oe, s2_l_out, s2_l_oe, s2_r_out, s2_r_oe;
    logic [4*N-1:0] lvl_out;

    int checks = 0;
    int errors = 0;
    logic in_reset = 1'b1;
    logic [N-1:0] msr [2];
    logic [N-1:0] mlat [2];

    always #10 clk = ~clk;

    lcd_dual_driver #(.CH(N)) u0 (
        .clk(clk), .rst_n(rst_n), .shift_stb(shift_stb), .latch_stb(latch_stb),
        .alt_in(alt_in), .dual_mode(dual_mode), .dir_sec1(dir_sec1), .dir_sec2(dir_sec2),
        .s1_l_in(s1_l_in), .s1_l_out(s1_l_out), .s1_l_oe(s1_l_oe),
        .s1_r_in(s1_r_in), .s1_r_out(s1_r_out), .s1_r_oe(s1_r_oe),
        .s2_l_in(s2_l_in), .s2_l_out(s2_l_out), .s2_l_oe(s2_l_oe),
        .s2_r_in(s2_r_in), .s2_r_out(s2_r_out), .s2_r_oe(s2_r_oe),
        .lvl_out(lvl_out)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Compare every channel code and the serial pins of both sections to the model.
    task automatic check_all(input string tag);
        for (int s = 0; s < 2; s++) begin
            logic dir, lo, loe, ro, roe;
            int bad = -1;
            logic [1:0] got_b = 2'b00, exp_b = 2'b00;
            for (int i = 0; i < N; i++) begin
                logic [1:0] got, expv;
                logic a;
                a = (in_reset ? 1'b0 : alt_in) ^ (s == 1 && dual_mode);
                expv = {~mlat[s][i], a};
                got = lvl_out[2*(s*N+i) +: 2];
                if (got !== expv && bad < 0) begin bad = i; got_b = got; exp_b = expv; end
            end
            checks++;
            if (bad >= 0) begin
                errors++;
                $display("FAIL R8/R9 %s sec%0d ch%0d level got %b expected %b", tag, s+1, bad, got_b, exp_b);
            end
            dir = (s == 0) ? dir_sec1 : dir_sec2;
            lo  = (s == 0) ? s1_l_out : s2_l_out;
            loe = (s == 0) ? s1_l_oe  : s2_l_oe;
            ro  = (s == 0) ? s1_r_out : s2_r_out;
            roe = (s == 0) ? s1_r_oe  : s2_r_oe;
            checks++;
            if (in_reset) begin
                if ({loe, roe, lo, ro} !== 4'b0) begin
                    errors++;
                    $display("FAIL R1 %s sec%0d pins got %b expected 0000", tag, s+1, {loe, roe, lo, ro});
                end
            end else begin
                logic [3:0] e;
                e = dir ? {1'b1, 1'b0, msr[s][0], 1'b0} : {1'b0, 1'b1, 1'b0, msr[s][N-1]};
                if ({loe, roe, lo, ro} !== e) begin
                    errors++;
                    $display("FAIL R4/R5 %s sec%0d pins got %b expected %b", tag, s+1, {loe, roe, lo, ro}, e);
                end
            end
        end
    endtask

    // One strobe pulse on pin 0 (shift_stb) or 1 (latch_stb), with data d1/d2.
    task automatic pulse(input int which, input logic d1, input logic d2);
        if (dir_sec1) begin s1_r_in = d1; s1_l_in = ~d1; end else begin s1_l_in = d1; s1_r_in = ~d1; end
        if (dir_sec2) begin s2_r_in = d2; s2_l_in = ~d2; end else begin s2_l_in = d2; s2_r_in = ~d2; end
        if (which == 0) shift_stb = 1'b1; else latch_stb = 1'b1;
        repeat (6) @(negedge clk);
        check_all("R10 rising edge");
        if (which == 0) shift_stb = 1'b0; else latch_stb = 1'b0;
        repeat (6) @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            int shift_pin;
            logic din;
            logic dir;
            shift_pin = (s == 1 && dual_mode) ? 1 : 0;   // R6 / R7 roles
            dir = (s == 0) ? dir_sec1 : dir_sec2;
            din = (s == 0) ? d1 : d2;
            if (which == shift_pin)
                msr[s] = dir ? {din, msr[s][N-1:1]} : {msr[s][N-2:0], din};  // R2 / R3 order
            else
                mlat[s] = msr[s];
        end
        check_all(dual_mode ? "R7 after fall" : "R6 after fall");
    endtask

    task automatic do_reset();
        alt_in = 1'b0;
        rst_n = 1'b0;
        in_reset = 1'b1;
        repeat (4) @(negedge clk);
        for (int s = 0; s < 2; s++) begin msr[s] = '0; mlat[s] = '0; end
        check_all("R1 in reset");
        rst_n = 1'b1;
        in_reset = 1'b0;
        repeat (4) @(negedge clk);
        check_all("R1 after release");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        for (int m = 0; m < 2; m++) begin
            for (int d = 0; d < 4; d++) begin
                dual_mode = m[0];
                dir_sec1 = d[0];
                dir_sec2 = d[1];
                repeat (4) @(negedge clk);
                check_all("R4 direction change");
                // Fill both sections via pin 0, then via pin 1 (covers R5 cascade).
                for (int j = 0; j < N; j++)
                    pulse(0, 1'((j * (d + 3) + m) % 3 == 0), 1'((j + d) % 4 < 2));
                for (int j = 0; j < N; j++)
                    pulse(1, 1'((j ^ d) & 1), 1'(((j * 5 + m) >> 1) & 1));
                pulse(0, 1'b1, 1'b0);
                pulse(1, 1'b0, 1'b1);
                // R8: alternation flips the low code bit only.
                alt_in = ~alt_in;
                repeat (5) @(negedge clk);
                check_all("R8 alt toggle");
            end
        end
        // R9: shifting without latch leaves outputs alone (checked each pulse), then reset again.
        dual_mode = 1'b0;
        pulse(0, 1'b1, 1'b1);
        do_reset();
        summary();
        $finish;
    end
endmodule